// File: doc/BRIEF.md
# Recovery Loop Reset, Calibration and Reference-Hold Sequencer

This block sequences the digital control of a clock and data recovery loop. It watches a reset/calibrate pin and accepts a pulse as a reset only when the pin has stayed high for a minimum time. The minimum time is measured with a counter on a free-running clock whose period is a parameter. When a valid pulse is released, the block puts the loop into calibration and then into acquisition. Once the loop reports lock it moves to tracking.

A lock-to-reference input is active low. While it is asserted, the loop stops following the incoming data. If a reference clock is present, the loop is steered onto that reference. If no reference is present, the oscillator frequency control word is frozen at its last value until the input is released.

The block also applies the output controls:
- a squelch input forces the retimed data to zero;
- a disable input gates off the recovered clock.

A change of the rate select input while the loop is running raises a sticky flag that parks the loop until a new valid reset arrives. After power-on reset the sequencer waits in its idle state for that first valid pulse.

Top module: `recov_ctrl`

## Requirements
- R1: A high pulse on `cal_pin` counts as a reset only when it is sampled high on at least MIN_CYC consecutive rising clock edges, where MIN_CYC = ceil(MIN_RESET_PS / CLK_PERIOD_PS) (125 with the defaults). A shorter pulse changes no output.
- R2: `seq_state` is encoded as IDLE=0, RESET_HELD=1, CALIBRATE=2, ACQUIRE=3, TRACK=4, HOLD=5. The clock edge that samples `cal_pin` high for the MIN_CYC-th time moves the state to RESET_HELD from any state, and the state stays there while the pin is high. `loop_rst` is high in IDLE and RESET_HELD.
- R3: The first edge that samples `cal_pin` low in RESET_HELD enters CALIBRATE, with `cal_run` high. CALIBRATE moves to ACQUIRE on the edge that samples `cal_done` high, or else after exactly CAL_TIMEOUT cycles (64 by default). In ACQUIRE, `follow_data` is high.
- R4: ACQUIRE moves to TRACK on an edge that samples `lock_ok` high, and `tracking` is then high. TRACK returns to ACQUIRE on an edge that samples `lock_ok` low.
- R5: An edge that samples `ltr_n` low in ACQUIRE or TRACK enters HOLD, and `follow_data` is then low.
- R6: In HOLD with `ref_present` high, `ref_steer` is high and `fcw_out` equals `fcw_in`.
- R7: In HOLD with `ref_present` low, `fcw_out` equals the `fcw_in` value sampled on the edge that entered HOLD, and it ignores later changes of `fcw_in`. An edge that samples `ltr_n` high in HOLD returns the state to ACQUIRE.
- R8: While `squelch` is high, `data_out` is all zeros. Otherwise `data_out` equals `data_in`.
- R9: `clk_en` is the inverse of `clk_off`.
- R10: A change of `rate_sel` sampled in CALIBRATE, ACQUIRE, TRACK or HOLD sets `rst_req` on that edge, and the next edge moves the state to IDLE. A change sampled in IDLE or RESET_HELD does not set the flag. `rst_req` is cleared only by a valid reset (R1, R2).
- R11: In IDLE and RESET_HELD, `fcw_out` equals FCW_INIT (16'h8000 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cal_pin | input | 1 | Reset/calibrate request, active high, width qualified |
| rate_sel | input | 1 | Line rate select |
| ltr_n | input | 1 | Lock-to-reference request, active low |
| ref_present | input | 1 | A reference clock is available |
| cal_done | input | 1 | Calibration finished strobe from the loop |
| lock_ok | input | 1 | Loop frequency lock status |
| fcw_in | input | FCW_W | Frequency control word from the loop filter |
| squelch | input | 1 | Force recovered data to zero |
| clk_off | input | 1 | Gate off the recovered clock |
| data_in | input | DATA_W | Retimed data before the squelch gate |
| fcw_out | output | FCW_W | Frequency control word to the oscillator |
| seq_state | output | 3 | Sequencer state code |
| loop_rst | output | 1 | Loop held in its known initial state |
| cal_run | output | 1 | Loop calibration running |
| follow_data | output | 1 | Loop acquires or tracks incoming data |
| tracking | output | 1 | Loop is in tracking |
| ref_steer | output | 1 | Loop steered to the reference |
| rst_req | output | 1 | A rate change is waiting for a reset |
| data_out | output | DATA_W | Recovered data after squelch |
| clk_en | output | 1 | Recovered clock enable |

## Verification
The bench probes pulses one cycle shorter than the qualifying width and pulses exactly at that width. A counter that is off by one would either park the loop on a glitch or reject a legal reset.

It counts the cycles spent in calibration when no done strobe arrives. It also changes the frequency word after HOLD is entered without a reference, then adds and removes the reference. A design that sampled the word one cycle late, or let it follow the filter, would show the wrong value.

Rate changes are applied while running, while idle and during a held reset. Short pulses that follow a rate change must leave the sticky flag set.

// File: rtl/recov_pkg.sv
package recov_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RST_HELD = 3'd1,
    ST_CAL      = 3'd2,
    ST_ACQ      = 3'd3,
    ST_TRACK    = 3'd4,
    ST_HOLD     = 3'd5
  } seq_st_e;

  // number of whole clock periods covering a minimum duration
  function automatic int unsigned cycles_for(int unsigned min_ps, int unsigned per_ps);
    return (min_ps + per_ps - 1) / per_ps;
  endfunction

  // states in which the loop runs from calibration on
  function automatic logic loop_running(seq_st_e s);
    return (s == ST_CAL) || (s == ST_ACQ) || (s == ST_TRACK) || (s == ST_HOLD);
  endfunction

endpackage

// File: rtl/rc_pulse_qual.sv
module rc_pulse_qual #(
  parameter int unsigned MIN_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_pin,
  output logic valid_o
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (!cal_pin) begin
      hi_cnt <= '0;
    end else if (hi_cnt != CW'(MIN_CYC)) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // the edge that sees the pin high for the MIN_CYC-th time
  assign valid_o = cal_pin && (hi_cnt == CW'(MIN_CYC - 1));

  // R1: a pulse qualifies at most once, however long it lasts
  assert_single_qual_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

endmodule

// File: rtl/rc_seq_fsm.sv
module rc_seq_fsm
  import recov_pkg::*;
#(
  parameter int unsigned CAL_TIMEOUT = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    valid_rst,
  input  logic    cal_pin,
  input  logic    ltr_n,
  input  logic    lock_ok,
  input  logic    cal_done,
  input  logic    rate_sel,
  output seq_st_e state_o,
  output logic    rst_req_o
);
  localparam int unsigned TW = $clog2(CAL_TIMEOUT + 1);

  seq_st_e       state, state_nx;
  logic [TW-1:0] cal_tmr;
  logic          rate_q;
  logic          rate_chg;
  logic          cal_expire;
  logic          req_set;

  assign rate_chg   = rate_sel != rate_q;
  assign cal_expire = (state == ST_CAL) && (cal_tmr == TW'(CAL_TIMEOUT - 1));
  assign req_set    = rate_chg && loop_running(state);

  always_comb begin
    state_nx = state;
    if (valid_rst) begin
      state_nx = ST_RST_HELD;
    end else if (rst_req_o && loop_running(state)) begin
      state_nx = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:     state_nx = ST_IDLE;
        ST_RST_HELD: if (!cal_pin) state_nx = ST_CAL;
        ST_CAL:      if (cal_done || cal_expire) state_nx = ST_ACQ;
        ST_ACQ: begin
          if (!ltr_n)       state_nx = ST_HOLD;
          else if (lock_ok) state_nx = ST_TRACK;
        end
        ST_TRACK: begin
          if (!ltr_n)        state_nx = ST_HOLD;
          else if (!lock_ok) state_nx = ST_ACQ;
        end
        ST_HOLD:     if (ltr_n) state_nx = ST_ACQ;
        default:     state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cal_tmr   <= '0;
      rate_q    <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      state   <= state_nx;
      rate_q  <= rate_sel;
      cal_tmr <= (state == ST_CAL) ? cal_tmr + 1'b1 : '0;
      if (valid_rst)    rst_req_o <= 1'b0;
      else if (req_set) rst_req_o <= 1'b1;
    end
  end

  assign state_o = state;

  // R2: RESET_HELD is only entered on a qualified pulse
  assert_held_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RST_HELD && !valid_rst) |=> state != ST_RST_HELD);

  // R3: releasing a held reset starts calibration
  assert_release_cal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RST_HELD && !cal_pin) |=> state == ST_CAL);

  // R3: calibration never outlives its timeout
  assert_cal_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAL) |-> (cal_tmr < TW'(CAL_TIMEOUT)));

  // R5: a lock-to-reference request while following data enters HOLD
  assert_ltr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ACQ || state == ST_TRACK) && !ltr_n && !valid_rst && !rst_req_o)
      |=> state == ST_HOLD);

  // R10: the reset-required flag persists until a qualified pulse
  assert_req_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o && !valid_rst) |=> rst_req_o);

endmodule

// File: rtl/rc_fcw_path.sv
module rc_fcw_path
  import recov_pkg::*;
#(
  parameter int unsigned FCW_W    = 16,
  parameter logic [FCW_W-1:0] FCW_INIT = FCW_W'(1) << (FCW_W - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_st_e          state,
  input  logic             ref_present,
  input  logic [FCW_W-1:0] fcw_in,
  output logic [FCW_W-1:0] fcw_out,
  output logic             ref_steer
);
  logic [FCW_W-1:0] fcw_q;
  logic             hold_norf;
  logic             in_reset;

  assign hold_norf = (state == ST_HOLD) && !ref_present;
  assign in_reset  = (state == ST_IDLE) || (state == ST_RST_HELD);
  assign ref_steer = (state == ST_HOLD) && ref_present;

  // last word seen before HOLD; frozen while HOLD lasts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fcw_q <= FCW_INIT;
    else if (state != ST_HOLD) fcw_q <= fcw_in;
  end

  always_comb begin
    if (in_reset)       fcw_out = FCW_INIT;
    else if (hold_norf) fcw_out = fcw_q;
    else                fcw_out = fcw_in;
  end

  // R7: without a reference the word does not move during HOLD
  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_norf && $past(hold_norf)) |-> (fcw_out == $past(fcw_out)));

endmodule

// File: rtl/rc_out_gate.sv
module rc_out_gate #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic              squelch,
  input  logic              clk_off,
  output logic [DATA_W-1:0] data_out,
  output logic              clk_en
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign data_out[i] = data_in[i] & ~squelch;
  end

  assign clk_en = ~clk_off;

endmodule

// File: rtl/recov_ctrl.sv
module recov_ctrl
  import recov_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned MIN_RESET_PS  = 1000000,
  parameter int unsigned CAL_TIMEOUT   = 64,
  parameter int unsigned FCW_W         = 16,
  parameter int unsigned DATA_W        = 8,
  parameter logic [FCW_W-1:0] FCW_INIT = FCW_W'(1) << (FCW_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_pin,
  input  logic              rate_sel,
  input  logic              ltr_n,
  input  logic              ref_present,
  input  logic              cal_done,
  input  logic              lock_ok,
  input  logic [FCW_W-1:0]  fcw_in,
  input  logic              squelch,
  input  logic              clk_off,
  input  logic [DATA_W-1:0] data_in,
  output logic [FCW_W-1:0]  fcw_out,
  output logic [2:0]        seq_state,
  output logic              loop_rst,
  output logic              cal_run,
  output logic              follow_data,
  output logic              tracking,
  output logic              ref_steer,
  output logic              rst_req,
  output logic [DATA_W-1:0] data_out,
  output logic              clk_en
);
  localparam int unsigned MIN_CYC = cycles_for(MIN_RESET_PS, CLK_PERIOD_PS);

  logic    valid_rst;
  seq_st_e state;

  rc_pulse_qual #(.MIN_CYC(MIN_CYC)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .cal_pin (cal_pin),
    .valid_o (valid_rst)
  );

  rc_seq_fsm #(.CAL_TIMEOUT(CAL_TIMEOUT)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_rst (valid_rst),
    .cal_pin   (cal_pin),
    .ltr_n     (ltr_n),
    .lock_ok   (lock_ok),
    .cal_done  (cal_done),
    .rate_sel  (rate_sel),
    .state_o   (state),
    .rst_req_o (rst_req)
  );

  rc_fcw_path #(.FCW_W(FCW_W), .FCW_INIT(FCW_INIT)) u_fcw (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .ref_present (ref_present),
    .fcw_in      (fcw_in),
    .fcw_out     (fcw_out),
    .ref_steer   (ref_steer)
  );

  rc_out_gate #(.DATA_W(DATA_W)) u_gate (
    .data_in  (data_in),
    .squelch  (squelch),
    .clk_off  (clk_off),
    .data_out (data_out),
    .clk_en   (clk_en)
  );

  assign seq_state   = state;
  assign loop_rst    = (state == ST_IDLE) || (state == ST_RST_HELD);
  assign cal_run     = (state == ST_CAL);
  assign follow_data = (state == ST_ACQ) || (state == ST_TRACK);
  assign tracking    = (state == ST_TRACK);

  // R4: TRACK is reached only from ACQUIRE with lock reported
  assert_track_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && !$past(tracking)) |-> ($past(state) == ST_ACQ && $past(lock_ok)));

endmodule

// File: tb/test_recov_ctrl.sv
module test_recov_ctrl;
  localparam int MIN  = 125;
  localparam int CALT = 64;
  localparam logic [15:0] INIT = 16'h8000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cal_pin = 0, rate_sel = 0, ltr_n = 1, ref_present = 0;
  logic cal_done = 0, lock_ok = 0, squelch = 0, clk_off = 0;
  logic [15:0] fcw_in = 16'h1234;
  logic [7:0]  data_in = 8'h00;
  logic [15:0] fcw_out;
  logic [2:0]  seq_state;
  logic loop_rst, cal_run, follow_data, tracking, ref_steer, rst_req, clk_en;
  logic [7:0]  data_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  recov_ctrl i_recov_ctrl (
    .clk(clk), .rst_n(rst_n), .cal_pin(cal_pin), .rate_sel(rate_sel),
    .ltr_n(ltr_n), .ref_present(ref_present), .cal_done(cal_done),
    .lock_ok(lock_ok), .fcw_in(fcw_in), .squelch(squelch), .clk_off(clk_off),
    .data_in(data_in), .fcw_out(fcw_out), .seq_state(seq_state),
    .loop_rst(loop_rst), .cal_run(cal_run), .follow_data(follow_data),
    .tracking(tracking), .ref_steer(ref_steer), .rst_req(rst_req),
    .data_out(data_out), .clk_en(clk_en)
  );

  function automatic logic [7:0] exp_data(logic [7:0] d, logic sq);
    return sq ? 8'h00 : d;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  // drive cal_pin high for n sampling edges, then low
  task automatic pulse(int n, bit release_it);
    cal_pin = 1'b1;
    cycles(n);
    if (release_it) cal_pin = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    int n;
    void'($urandom(32'd2024));
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    check("R2 reset state", seq_state, 0);
    check("R11 reset fcw", fcw_out, INIT);
    check("R2 reset loop_rst", loop_rst, 1);
    check("R10 reset flag", rst_req, 0);

    // R10: rate change in IDLE does not set the flag
    rate_sel = 1; cycles(2);
    check("R10 idle rate change", rst_req, 0);

    // R1: short pulses ignored
    pulse(MIN - 1, 1); cycles(2);
    check("R1 short by one", seq_state, 0);
    for (int k = 0; k < 3; k++) begin
      pulse(1 + ($urandom % (MIN - 1)), 1); cycles(1);
      check("R1 random short", seq_state, 0);
    end

    // R2: exact-width pulse qualifies and holds while high
    pulse(MIN, 0);
    check("R2 enter held", seq_state, 1);
    check("R2 loop_rst held", loop_rst, 1);
    check("R11 held fcw", fcw_out, INIT);
    cycles(5);
    check("R2 stays held", seq_state, 1);
    cal_pin = 0; cycles(1);
    check("R3 calibrate", seq_state, 2);
    check("R3 cal_run", cal_run, 1);
    n = 0;
    while (seq_state == 3'd2 && n < 1000) begin n++; cycles(1); end
    check("R3 timeout length", n, CALT);
    check("R3 acquire", seq_state, 3);
    check("R3 follow", follow_data, 1);

    // R4: lock handling
    lock_ok = 1; cycles(1);
    check("R4 track", seq_state, 4);
    check("R4 tracking", tracking, 1);
    lock_ok = 0; cycles(1);
    check("R4 lock lost", seq_state, 3);
    lock_ok = 1; cycles(1);
    check("R4 track again", seq_state, 4);

    // R5/R7: hold without reference
    held = 16'($urandom); fcw_in = held; cycles(1);
    ltr_n = 0; cycles(1);
    check("R5 hold", seq_state, 5);
    check("R5 not following", follow_data, 0);
    check("R7 frozen", fcw_out, held);
    for (int k = 0; k < 4; k++) begin
      fcw_in = 16'($urandom); cycles(1);
      check("R7 frozen vs changes", fcw_out, held);
    end
    // R6: reference appears
    ref_present = 1; #1;
    check("R6 steer", ref_steer, 1);
    check("R6 fcw follows", fcw_out, fcw_in);
    ref_present = 0; #1;
    check("R7 back to frozen", fcw_out, held);
    cycles(1);
    ltr_n = 1; cycles(1);
    check("R7 release", seq_state, 3);
    check("R7 fcw live", fcw_out, fcw_in);

    // R3: done strobe ends calibration early
    lock_ok = 0;
    pulse(MIN, 1); cycles(3);
    check("R3 in cal", seq_state, 2);
    cal_done = 1; cycles(1);
    check("R3 done strobe", seq_state, 3);
    cal_done = 0;

    // R10: rate change while running
    rate_sel = 0; cycles(1);
    check("R10 flag set", rst_req, 1);
    check("R10 not yet idle", seq_state, 3);
    cycles(1);
    check("R10 parked idle", seq_state, 0);
    pulse(MIN - 1, 1); cycles(3);
    check("R10 short keeps flag", rst_req, 1);
    check("R10 short keeps idle", seq_state, 0);
    pulse(MIN, 0);
    check("R10 cleared by reset", rst_req, 0);
    rate_sel = 1; cycles(2);
    check("R10 change during held", rst_req, 0);
    cal_pin = 0; cycles(1);
    check("R10 calibrate after held", seq_state, 2);

    // R8/R9: random output gating
    for (int k = 0; k < 150; k++) begin
      data_in = 8'($urandom); squelch = 1'($urandom); clk_off = 1'($urandom);
      #1;
      check("R8 data gate", data_out, exp_data(data_in, squelch));
      check("R9 clock gate", clk_en, !clk_off);
      cycles(1);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule